// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 64 interrupt request lines from on-chip modules and external pins and turns them into a single request to a processor. Each line passes through a two-flop synchronizer. It is then corrected for its fixed polarity: lines 0 to 4 are active low and every other line is active high. After that, each line is detected in its own edge or level mode.

Edge-mode lines latch a sticky pending bit that stays set until software clears it. Level-mode lines are pending for as long as their corrected level is active.

Among pending, enabled lines, the one with the highest 3-bit priority wins, and ties go to the lower line number. A small state machine offers the winner to the CPU as a 6-bit vector with a valid flag. On acknowledge it freezes that vector, and it only returns to arbitration once the serviced line stops being pending and enabled.

The states are:
- ST_IDLE: no vector is offered.
- ST_OFFER: the vector tracks the current winner.
- ST_HELD: the vector is frozen after an acknowledge.

The transitions are:
- ST_IDLE to ST_OFFER: some enabled line is pending.
- ST_OFFER to ST_IDLE: no enabled line is pending any more.
- ST_OFFER to ST_HELD: ack is high while some enabled line is pending.
- ST_HELD to ST_IDLE: the held line is no longer both pending and enabled.

Configuration uses a write-only port. With address bit 6 at 0, a write stores the word {enable, edge mode, priority} for the line given by address bits 5:0. With address bit 6 at 1, a write clears the pending bit of that line.

Top module: `irq_vic`

## Requirements
- R1: Lines 0 to 4 are asserted by a low input level, or by a falling edge in edge mode. All other lines, including 26 and 27, are asserted by a high level or a rising edge.
- R2: An input change reaches cpu_req at the third rising clock edge after it is applied. vec_valid follows at the next edge. In level mode, pending follows the corrected level.
- R3: In edge mode (cfg_wdata[3]=1), an asserting edge sets a pending bit. That bit survives the input returning inactive and is cleared only by a write with cfg_addr[6]=1 and cfg_addr[5:0] equal to the line number.
- R4: A clear write to a line in level mode (cfg_wdata[3]=0) has no effect while its input is still active.
- R5: A line with its enable bit (cfg_wdata[4]) at 0 never raises cpu_req. An edge latched while the line is disabled does become visible once the line is enabled.
- R6: cpu_req is high exactly when at least one enabled line is pending. When cpu_req is low, vec_valid is low one cycle later.
- R7: The offered vector is the pending, enabled line with the largest priority cfg_wdata[2:0]. Among lines of equal priority, the lowest line number wins.
- R8: vec_valid is high in ST_OFFER and ST_HELD and low in ST_IDLE. It is only high one cycle after cpu_req was high.
- R9: An ack while a vector is offered freezes vec_id, even if a higher-priority line becomes pending. The freeze is released when the held line is cleared, deasserts in level mode, or is disabled. The next winner is then offered.
- R10: After reset, all lines are disabled, in level mode, at priority 0 and not pending, and cpu_req, vec_valid and vec_id are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Raw interrupt lines, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Bit 6 selects clear (1) or config (0); bits 5:0 give the line number |
| cfg_wdata | input | 5 | {enable, edge mode, priority[2:0]} for config writes |
| ack | input | 1 | CPU acknowledge of the offered vector |
| cpu_req | output | 1 | Request to the CPU |
| vec_valid | output | 1 | Vector is offered or held |
| vec_id | output | 6 | Number of the offered line |

## Verification
The hardest situation to reach is a held vector while a higher-priority line arrives, followed by each of the three ways the freeze is released. The bench reaches it with a directed sequence. It latches an edge, acknowledges it, and raises a priority-7 line during the hold. It then releases the hold in turn by a clear write, by disabling the held line, and by dropping a held level line. Each time it checks which vector is offered next. Random rounds then configure all 64 lines with random modes, enables and priorities. They flip random inputs with interleaved clears, and compare against a bench model of pending state and arbitration.

// File: rtl/irq_vic_pkg.sv
package irq_vic_pkg;
    localparam int PRIO_W = 3;

    typedef struct packed {
        logic              en;
        logic              edge_m;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } vic_state_t;
endpackage

// File: rtl/irq_vic_src.sv
module irq_vic_src
    import irq_vic_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     irq_raw,
    input  logic     cfg_wr,
    input  src_cfg_t cfg_in,
    input  logic     clr,
    output src_cfg_t cfg_q,
    output logic     pend
);
    localparam logic IDLE_LVL = ACTIVE_LOW;

    logic sync1, sync2, act_prev;
    logic act_now, rise;

    // two-flop synchronizer, then the edge history of the corrected level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1    <= IDLE_LVL;
            sync2    <= IDLE_LVL;
            act_prev <= 1'b0;
        end else begin
            sync1    <= irq_raw;
            sync2    <= sync1;
            act_prev <= act_now;
        end
    end

    assign act_now = sync2 ^ ACTIVE_LOW;
    assign rise    = act_now & ~act_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_in;
        end
    end

    // level: follow the line; edge: sticky, a new edge wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!cfg_q.edge_m) begin
            pend <= act_now;
        end else begin
            pend <= rise | (pend & ~clr);
        end
    end
endmodule

// File: rtl/irq_vic_arb.sv
module irq_vic_arb
    import irq_vic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [VEC_W-1:0]          win_id
);
    logic [PRIO_W-1:0] best;

    // strict greater-than keeps the lower index on a tie
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                found  = 1'b1;
                best   = prio_flat[i*PRIO_W +: PRIO_W];
                win_id = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vic.sv
module irq_vic
    import irq_vic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LOW = 5,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [VEC_W:0]     cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               ack,
    output logic               cpu_req,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_id
);
    logic [NUM_SRC-1:0]        pend_v, en_v, edge_v, live;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      any_live, held_live;
    logic [VEC_W-1:0]          win_id;
    logic [VEC_W-1:0]          vec_q;
    logic                      offer_s, held_s;
    vic_state_t                state_q, state_d;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        src_cfg_t c;
        logic     hit;
        assign hit = cfg_we && (cfg_addr[VEC_W-1:0] == VEC_W'(g));
        irq_vic_src #(.ACTIVE_LOW(1'(g < NUM_LOW))) u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_raw (irq_in[g]),
            .cfg_wr  (hit && !cfg_addr[VEC_W]),
            .cfg_in  (src_cfg_t'(cfg_wdata)),
            .clr     (hit && cfg_addr[VEC_W]),
            .cfg_q   (c),
            .pend    (pend_v[g])
        );
        assign en_v[g]                        = c.en;
        assign edge_v[g]                      = c.edge_m;
        assign prio_flat[g*PRIO_W +: PRIO_W]  = c.prio;
    end

    assign live      = pend_v & en_v;
    assign any_live  = |live;
    assign held_live = live[vec_q];
    assign cpu_req   = any_live;

    irq_vic_arb #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .req       (live),
        .prio_flat (prio_flat),
        .found     (),
        .win_id    (win_id)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_live) state_d = ST_OFFER;
            ST_OFFER: begin
                if (!any_live)  state_d = ST_IDLE;
                else if (ack)   state_d = ST_HELD;
            end
            ST_HELD:  if (!held_live) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: vector tracks the winner until an ack freezes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q != ST_HELD && state_d != ST_HELD) begin
            vec_q <= win_id;
        end
    end

    assign offer_s   = (state_q == ST_OFFER);
    assign held_s    = (state_q == ST_HELD);
    assign vec_valid = offer_s | held_s;
    assign vec_id    = vec_q;
endmodule

// File: rtl/irq_vic_chk.sv
module irq_vic_chk #(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_id,
    input logic               ack,
    input logic               cfg_we,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] edge_mask,
    input logic               offer,
    input logic               held
);
    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> !vec_valid);

    // R8
    offer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cpu_req));

    // R9
    ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer && ack && cpu_req |=> held && $stable(vec_id));

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && $past(held) |-> $stable(vec_id));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
        // R3
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            edge_mask[g] && pend[g] && !cfg_we |=> pend[g]);
    end
endmodule

bind irq_vic irq_vic_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .vec_valid (vec_valid),
    .vec_id    (vec_id),
    .ack       (ack),
    .cfg_we    (cfg_we),
    .pend      (pend_v),
    .edge_mask (edge_v),
    .offer     (offer_s),
    .held      (held_s)
);

// File: tb/irq_vic_tb.sv
module irq_vic_tb;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] lvl;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [4:0]    cfg_wdata = '0;
    logic          ack = 1'b0;
    logic          cpu_req, vec_valid;
    logic [5:0]    vec_id;

    int n_chk  = 0;
    int n_fail = 0;

    bit m_en [NS];
    bit m_edge [NS];
    int m_prio [NS];
    bit m_pend [NS];

    always #5 clk = ~clk;

    irq_vic u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(lvl), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack),
        .cpu_req(cpu_req), .vec_valid(vec_valid), .vec_id(vec_id)
    );

    function automatic bit act(int i);
        return (i < 5) ? !lvl[i] : lvl[i];
    endfunction

    function automatic bit exp_live(int i);
        return m_en[i] && (m_edge[i] ? m_pend[i] : act(i));
    endfunction

    function automatic int exp_win();
        int w = -1;
        int bp = -1;
        for (int i = 0; i < NS; i++)
            if (exp_live(i) && m_prio[i] > bp) begin
                bp = m_prio[i];
                w = i;
            end
        return w;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lvl = 64'h1F;
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 0; m_edge[i] = 0; m_prio[i] = 0; m_pend[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_cfg(input int s, input bit en, input bit edg, input int pr);
        cfg_we = 1'b1;
        cfg_addr = {1'b0, 6'(s)};
        cfg_wdata = {en, edg, 3'(pr)};
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[s] = en; m_edge[s] = edg; m_prio[s] = pr;
    endtask

    task automatic wr_clr(input int s);
        cfg_we = 1'b1;
        cfg_addr = {1'b1, 6'(s)};
        cfg_wdata = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        if (m_edge[s]) m_pend[s] = 0;
    endtask

    task automatic set_in(input int s, input bit v);
        bit was;
        was = act(s);
        lvl[s] = v;
        if (m_edge[s] && !was && act(s)) m_pend[s] = 1;
    endtask

    task automatic pulse(input int s);
        set_in(s, ~lvl[s]);
        repeat (2) @(negedge clk);
        set_in(s, ~lvl[s]);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic check_out(input string tag);
        int w;
        w = exp_win();
        chk({tag, " cpu_req"}, int'(cpu_req), int'(w >= 0));
        chk({tag, " vec_valid"}, int'(vec_valid), int'(w >= 0));
        if (w >= 0) chk({tag, " vec_id"}, int'(vec_id), w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        lvl = 64'h1F;
        void'($urandom(32'd20240611));
        do_reset();

        // R10 reset state
        chk("R10 cpu_req", int'(cpu_req), 0);
        chk("R10 vec_valid", int'(vec_valid), 0);
        chk("R10 vec_id", int'(vec_id), 0);
        set_in(10, 1'b1);
        settle();
        chk("R10 disabled line", int'(cpu_req), 0);

        // R1 polarity, R2 latency
        do_reset();
        wr_cfg(2, 1, 0, 1);
        settle();
        chk("R1 high idle on low line", int'(cpu_req), 0);
        set_in(2, 1'b0);
        @(negedge clk); chk("R2 edge1", int'(cpu_req), 0);
        @(negedge clk); chk("R2 edge2", int'(cpu_req), 0);
        @(negedge clk); chk("R2 edge3", int'(cpu_req), 1);
        chk("R2 valid lag", int'(vec_valid), 0);
        @(negedge clk); chk("R2 valid edge4", int'(vec_valid), 1);
        chk("R1 vec low line", int'(vec_id), 2);
        set_in(2, 1'b1);
        settle();
        check_out("R2 level drop");
        wr_cfg(30, 1, 0, 4);
        set_in(30, 1'b1);
        settle();
        chk("R1 high line vec", int'(vec_id), 30);

        // R3 sticky edge, clear
        do_reset();
        wr_cfg(5, 1, 1, 2);
        pulse(5);
        settle();
        chk("R3 sticky", int'(cpu_req), 1);
        chk("R3 vec", int'(vec_id), 5);
        wr_clr(5);
        settle();
        chk("R3 cleared", int'(cpu_req), 0);
        wr_cfg(1, 1, 1, 2);
        pulse(1);
        settle();
        chk("R1 falling edge vec", int'(vec_id), 1);
        chk("R1 falling edge req", int'(cpu_req), 1);

        // R4 clear ignored for level
        do_reset();
        wr_cfg(40, 1, 0, 3);
        set_in(40, 1'b1);
        settle();
        wr_clr(40);
        settle();
        chk("R4 level after clear", int'(cpu_req), 1);
        chk("R4 vec", int'(vec_id), 40);

        // R5 enable masking
        do_reset();
        wr_cfg(6, 0, 1, 5);
        pulse(6);
        settle();
        chk("R5 masked", int'(cpu_req), 0);
        wr_cfg(6, 1, 1, 5);
        settle();
        chk("R5 latched shown", int'(cpu_req), 1);
        chk("R5 vec", int'(vec_id), 6);

        // R7 priority and tie
        do_reset();
        wr_cfg(20, 1, 0, 3);
        wr_cfg(12, 1, 0, 3);
        set_in(20, 1'b1);
        set_in(12, 1'b1);
        settle();
        chk("R7 tie lowest", int'(vec_id), 12);
        wr_cfg(50, 1, 0, 6);
        set_in(50, 1'b1);
        settle();
        chk("R7 higher prio", int'(vec_id), 50);

        // R9 freeze and the three releases
        do_reset();
        wr_cfg(8, 1, 1, 1);
        wr_cfg(9, 1, 0, 2);
        wr_cfg(60, 1, 1, 7);
        pulse(8);
        settle();
        chk("R9 offered", int'(vec_id), 8);
        do_ack();
        pulse(60);
        settle();
        chk("R9 frozen vec", int'(vec_id), 8);
        chk("R8 valid while held", int'(vec_valid), 1);
        wr_clr(8);
        settle();
        chk("R9 release by clear", int'(vec_id), 60);
        do_ack();
        set_in(9, 1'b1);
        settle();
        chk("R9 frozen again", int'(vec_id), 60);
        wr_cfg(60, 0, 1, 7);
        settle();
        chk("R9 release by disable", int'(vec_id), 9);
        do_ack();
        set_in(9, 1'b0);
        settle();
        chk("R9 release by level drop req", int'(cpu_req), 0);
        chk("R8 idle after release", int'(vec_valid), 0);

        // random rounds: R6 R7 R8 against the model
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int s = 0; s < NS; s++)
                wr_cfg(s, ($urandom % 4) != 0, $urandom % 2, $urandom % 8);
            settle();
            for (int st = 0; st < 80; st++) begin
                int nf;
                if ($urandom % 4 == 0) wr_clr($urandom % NS);
                nf = 1 + $urandom % 3;
                for (int k = 0; k < nf; k++) begin
                    int s;
                    s = $urandom % NS;
                    set_in(s, ~lvl[s]);
                end
                settle();
                check_out("R6 R7 R8 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule